// File: doc/BRIEF.md
# Ethernet Receive Frame Filter

This block sits after the receive MAC datapath. It takes each frame as a byte stream with start and end markers. With the last byte it also takes the frame's status: three error indications (CRC, alignment, code), the destination class that address matching found (unicast hit, multicast, broadcast), and whether the frame is a MAC control frame or a pause frame. One cycle after the last byte it issues a verdict in a single-cycle pulse. The verdict says whether to copy the frame to memory, gives the 3-bit receive channel and the forwarded byte count, and sets the end-of-packet descriptor flags for control, fragment and undersize frames.

The forwarded byte stream passes through a 4-byte delay line. When CRC passing is off, the delay line drops the trailing check sequence without any look-ahead. The bytes always appear on the output stream. A downstream writer uses the verdict to commit or discard them. Static configuration inputs control CRC handling, the copy rules for control and short frames, pause signalling, and the enable and channel of each of the broadcast, multicast and promiscuous acceptance paths. All configuration is zero after reset. In that state only unicast hits are accepted and the CRC is stripped.

Top module: `eth_rx_filter`

## Requirements
- R1: After reset, and in any cycle that follows a cycle with no input byte, `out_valid`, `dec_valid` and `pause_req` are low.
- R2: With `cfg_pass_fcs`=1, every input byte appears on `out_data` with `out_valid` one cycle later, unchanged. `dec_len` equals the full frame byte count.
- R3: With `cfg_pass_fcs`=0, the last 4 bytes of every frame are not forwarded and the other bytes keep their order. `dec_len` is the byte count minus 4, or 0 for frames of 4 bytes or fewer. The CRC rule is the same whatever the channel.
- R4: `dec_valid` pulses high for exactly the cycle after each byte that has `in_eof`=1, and at no other time.
- R5: A MAC control frame (`in_ctrl`=1) is dropped when `cfg_keep_ctrl`=0. When `cfg_keep_ctrl`=1 it is accepted with `dec_flag_ctrl`=1. This rule takes priority over every other rule.
- R6: `pause_req` pulses with the verdict of any frame that has `in_pause`=1 while `cfg_pause_en`=1, whether or not the frame is accepted.
- R7: A non-control frame with a full byte count (CRC included) below 64 is dropped unless `cfg_keep_short`=1. When kept, it carries `dec_flag_frag` if any of the three error inputs was set, and `dec_flag_under` otherwise. A 64-byte frame is not short.
- R8: A non-control, non-short frame with `in_ucast`=1 is always accepted on channel `in_ucast_chan`.
- R9: A broadcast frame is accepted on `cfg_bcast_chan` only when `cfg_bcast_en`=1.
- R10: A multicast frame is accepted on `cfg_mcast_chan` only when `cfg_mcast_en`=1.
- R11: A frame that no other path accepts is accepted on `cfg_prom_chan` when `cfg_prom_en`=1. Otherwise it is dropped and `dec_chan` reads 0.
- R12: The channel is chosen in this priority order: unicast hit, broadcast, multicast, promiscuous.
- R13: At most one descriptor flag is set per verdict, and a dropped frame carries no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pass_fcs | input | 1 | 1 forwards and counts the trailing CRC |
| cfg_keep_ctrl | input | 1 | Copy MAC control frames to memory |
| cfg_keep_short | input | 1 | Copy frames shorter than 64 bytes |
| cfg_pause_en | input | 1 | Signal pause frames to flow control |
| cfg_bcast_en | input | 1 | Accept broadcast frames |
| cfg_bcast_chan | input | 3 | Channel for broadcast frames |
| cfg_mcast_en | input | 1 | Accept multicast frames |
| cfg_mcast_chan | input | 3 | Channel for multicast frames |
| cfg_prom_en | input | 1 | Accept otherwise unmatched frames |
| cfg_prom_chan | input | 3 | Channel for promiscuous acceptance |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame; status is valid |
| in_data | input | 8 | Frame byte |
| in_crc_err | input | 1 | CRC error (at eof) |
| in_align_err | input | 1 | Alignment error (at eof) |
| in_code_err | input | 1 | Code error (at eof) |
| in_ucast | input | 1 | Unicast address hit (at eof) |
| in_ucast_chan | input | 3 | Channel of the unicast hit |
| in_mcast | input | 1 | Multicast destination (at eof) |
| in_bcast | input | 1 | Broadcast destination (at eof) |
| in_ctrl | input | 1 | MAC control frame (at eof) |
| in_pause | input | 1 | Pause frame (at eof) |
| out_valid | output | 1 | Forwarded byte present |
| out_data | output | 8 | Forwarded byte |
| out_last | output | 1 | Last forwarded byte of the frame |
| dec_valid | output | 1 | Verdict pulse |
| dec_accept | output | 1 | 1 copy to memory, 0 drop |
| dec_chan | output | 3 | Receive channel |
| dec_len | output | 16 | Forwarded byte count |
| dec_flag_ctrl | output | 1 | Descriptor CONTROL flag |
| dec_flag_frag | output | 1 | Descriptor FRAGMENT flag |
| dec_flag_under | output | 1 | Descriptor UNDERSIZE flag |
| pause_req | output | 1 | Pause indication to flow control |

## Verification
When frames arrive back to back, the verdict for one frame and the forwarding of the next frame's first byte happen in the same cycle. The byte counter restarts at that moment while the verdict registers still hold the previous count. The bench provokes this by sending frames with no idle cycle between them, in both CRC modes. The scoreboard then checks that each verdict arrives exactly one cycle after its end byte, with the length of its own frame, and that the byte queue stays in order across the frame boundary. A second overlap, a pause indication on a control frame that is dropped, is judged from the `pause_req` and `dec_accept` fields of the same verdict.

// File: rtl/eth_rxf_pkg.sv
package eth_rxf_pkg;
  localparam int unsigned CHAN_W = 3;
  typedef logic [CHAN_W-1:0] chan_t;

  typedef struct packed {
    logic  accept;
    chan_t chan;
    logic  f_ctrl;
    logic  f_frag;
    logic  f_under;
    logic  pause;
  } verdict_t;
endpackage

// File: rtl/eth_rxf_counter.sv
// Per-frame byte counter, saturating, restarting on the first byte.
module eth_rxf_counter #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  output logic [LEN_W-1:0] cnt_next
);
  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (in_valid) begin
      if (in_sof)
        cnt_d = LEN_W'(1);
      else if (cnt_q != CNT_MAX)
        cnt_d = cnt_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (in_valid)
      cnt_q <= cnt_d;
  end

  assign cnt_next = cnt_d;
endmodule

// File: rtl/eth_rxf_delay.sv
// Shift register of DEPTH stages advanced only when a byte arrives.
module eth_rxf_delay #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] stage_d;
    if (i == 0) begin : g_head
      assign stage_d = din;
    end else begin : g_body
      assign stage_d = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stage_q[i] <= '0;
      else if (shift_en)
        stage_q[i] <= stage_d;
    end
  end

  assign dout = stage_q[DEPTH-1];
endmodule

// File: rtl/eth_rxf_classify.sv
// End-of-frame decision: acceptance, channel, flags, forwarded length.
module eth_rxf_classify
  import eth_rxf_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MIN_FRAME = 64,
  parameter int unsigned FCS_BYTES = 4
) (
  input  logic [LEN_W-1:0] total_len,
  input  logic             st_err,
  input  logic             st_ucast,
  input  chan_t            st_ucast_chan,
  input  logic             st_mcast,
  input  logic             st_bcast,
  input  logic             st_ctrl,
  input  logic             st_pause,
  input  logic             cfg_pass_fcs,
  input  logic             cfg_keep_ctrl,
  input  logic             cfg_keep_short,
  input  logic             cfg_pause_en,
  input  logic             cfg_bcast_en,
  input  chan_t            cfg_bcast_chan,
  input  logic             cfg_mcast_en,
  input  chan_t            cfg_mcast_chan,
  input  logic             cfg_prom_en,
  input  chan_t            cfg_prom_chan,
  output verdict_t         verdict,
  output logic [LEN_W-1:0] fwd_len
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0] FCS_L = LEN_W'(FCS_BYTES);

  logic  addr_hit;
  chan_t addr_chan;
  logic  is_short;

  // address path in fixed priority
  always_comb begin
    addr_hit  = 1'b1;
    addr_chan = '0;
    if (st_ucast)
      addr_chan = st_ucast_chan;
    else if (st_bcast && cfg_bcast_en)
      addr_chan = cfg_bcast_chan;
    else if (st_mcast && cfg_mcast_en)
      addr_chan = cfg_mcast_chan;
    else if (cfg_prom_en)
      addr_chan = cfg_prom_chan;
    else
      addr_hit = 1'b0;
  end

  assign is_short = (total_len < MIN_L);

  always_comb begin
    verdict      = '0;
    verdict.chan = addr_chan;
    if (st_ctrl) begin
      verdict.accept = cfg_keep_ctrl;
      verdict.f_ctrl = cfg_keep_ctrl;
    end else if (is_short) begin
      verdict.accept  = cfg_keep_short;
      verdict.f_frag  = cfg_keep_short & st_err;
      verdict.f_under = cfg_keep_short & ~st_err;
    end else begin
      verdict.accept = addr_hit;
    end
    verdict.pause = st_pause & cfg_pause_en;
  end

  always_comb begin
    if (cfg_pass_fcs)
      fwd_len = total_len;
    else if (total_len > FCS_L)
      fwd_len = total_len - FCS_L;
    else
      fwd_len = '0;
  end
endmodule

// File: rtl/eth_rx_filter.sv
module eth_rx_filter
  import eth_rxf_pkg::*;
#(
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned MIN_FRAME = 64,
  parameter int unsigned FCS_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_pass_fcs,
  input  logic              cfg_keep_ctrl,
  input  logic              cfg_keep_short,
  input  logic              cfg_pause_en,
  input  logic              cfg_bcast_en,
  input  logic [CHAN_W-1:0] cfg_bcast_chan,
  input  logic              cfg_mcast_en,
  input  logic [CHAN_W-1:0] cfg_mcast_chan,
  input  logic              cfg_prom_en,
  input  logic [CHAN_W-1:0] cfg_prom_chan,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  input  logic              in_crc_err,
  input  logic              in_align_err,
  input  logic              in_code_err,
  input  logic              in_ucast,
  input  logic [CHAN_W-1:0] in_ucast_chan,
  input  logic              in_mcast,
  input  logic              in_bcast,
  input  logic              in_ctrl,
  input  logic              in_pause,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [CHAN_W-1:0] dec_chan,
  output logic [LEN_W-1:0]  dec_len,
  output logic              dec_flag_ctrl,
  output logic              dec_flag_frag,
  output logic              dec_flag_under,
  output logic              pause_req
);
  localparam logic [LEN_W-1:0] FCS_L = LEN_W'(FCS_BYTES);

  logic [LEN_W-1:0] cnt_next;
  logic [7:0]       dly_out;
  verdict_t         verdict;
  logic [LEN_W-1:0] fwd_len;

  eth_rxf_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .cnt_next (cnt_next)
  );

  eth_rxf_delay #(.DEPTH(FCS_BYTES), .W(8)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (in_valid),
    .din      (in_data),
    .dout     (dly_out)
  );

  eth_rxf_classify #(
    .LEN_W     (LEN_W),
    .MIN_FRAME (MIN_FRAME),
    .FCS_BYTES (FCS_BYTES)
  ) u_cls (
    .total_len      (cnt_next),
    .st_err         (in_crc_err | in_align_err | in_code_err),
    .st_ucast       (in_ucast),
    .st_ucast_chan  (in_ucast_chan),
    .st_mcast       (in_mcast),
    .st_bcast       (in_bcast),
    .st_ctrl        (in_ctrl),
    .st_pause       (in_pause),
    .cfg_pass_fcs   (cfg_pass_fcs),
    .cfg_keep_ctrl  (cfg_keep_ctrl),
    .cfg_keep_short (cfg_keep_short),
    .cfg_pause_en   (cfg_pause_en),
    .cfg_bcast_en   (cfg_bcast_en),
    .cfg_bcast_chan (cfg_bcast_chan),
    .cfg_mcast_en   (cfg_mcast_en),
    .cfg_mcast_chan (cfg_mcast_chan),
    .cfg_prom_en    (cfg_prom_en),
    .cfg_prom_chan  (cfg_prom_chan),
    .verdict        (verdict),
    .fwd_len        (fwd_len)
  );

  // forwarded stream: next state
  logic       emit;
  logic       ov_d, ol_d;
  logic [7:0] od_d;
  logic       ov_q, ol_q;
  logic [7:0] od_q;

  always_comb begin
    emit = in_valid & (cfg_pass_fcs | (cnt_next > FCS_L));
    ov_d = emit;
    ol_d = emit & in_eof;
    od_d = od_q;
    if (emit)
      od_d = cfg_pass_fcs ? in_data : dly_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ol_q <= 1'b0;
      od_q <= '0;
    end else begin
      ov_q <= ov_d;
      ol_q <= ol_d;
      if (emit)
        od_q <= od_d;
    end
  end

  // verdict: next state
  logic             dv_d, dv_q;
  logic             load_verdict;
  verdict_t         vr_q;
  logic [LEN_W-1:0] len_q;

  always_comb begin
    load_verdict = in_valid & in_eof;
    dv_d         = load_verdict;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      vr_q  <= '0;
      len_q <= '0;
    end else begin
      dv_q <= dv_d;
      if (load_verdict) begin
        vr_q  <= verdict;
        len_q <= fwd_len;
      end
    end
  end

  assign out_valid      = ov_q;
  assign out_data       = od_q;
  assign out_last       = ol_q;
  assign dec_valid      = dv_q;
  assign dec_accept     = dv_q & vr_q.accept;
  assign dec_chan       = vr_q.chan;
  assign dec_len        = len_q;
  assign dec_flag_ctrl  = dv_q & vr_q.f_ctrl;
  assign dec_flag_frag  = dv_q & vr_q.f_frag;
  assign dec_flag_under = dv_q & vr_q.f_under;
  assign pause_req      = dv_q & vr_q.pause;
endmodule

// File: rtl/eth_rx_filter_chk.sv
module eth_rx_filter_chk #(
  parameter int unsigned CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_pass_fcs,
  input logic          cfg_keep_ctrl,
  input logic          cfg_pause_en,
  input logic          cfg_bcast_en,
  input logic [CW-1:0] cfg_bcast_chan,
  input logic          in_valid,
  input logic          in_eof,
  input logic [7:0]    in_data,
  input logic          in_ucast,
  input logic          in_bcast,
  input logic          in_ctrl,
  input logic          in_pause,
  input logic          out_valid,
  input logic [7:0]    out_data,
  input logic          dec_valid,
  input logic          dec_accept,
  input logic [CW-1:0] dec_chan,
  input logic          dec_flag_ctrl,
  input logic          dec_flag_frag,
  input logic          dec_flag_under,
  input logic          pause_req
);
  assert_quiet_after_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (!out_valid && !dec_valid && !pause_req));

  assert_pass_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && cfg_pass_fcs) |-> (out_valid && out_data == $past(in_data)));

  assert_verdict_after_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_eof) |-> dec_valid);

  assert_verdict_only_after_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid && in_eof));

  assert_ctrl_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_eof && in_ctrl && !cfg_keep_ctrl) |-> !dec_accept);

  assert_pause_signal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_eof && in_pause && cfg_pause_en) |-> pause_req);

  assert_bcast_chan_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && in_eof && !in_ctrl && in_bcast && !in_ucast && cfg_bcast_en)
      |-> dec_chan == $past(cfg_bcast_chan));

  assert_flag_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ($onehot0({dec_flag_ctrl, dec_flag_frag, dec_flag_under}) &&
                   (dec_accept || !(dec_flag_ctrl || dec_flag_frag || dec_flag_under))));
endmodule

bind eth_rx_filter eth_rx_filter_chk #(.CW(eth_rxf_pkg::CHAN_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_pass_fcs   (cfg_pass_fcs),
  .cfg_keep_ctrl  (cfg_keep_ctrl),
  .cfg_pause_en   (cfg_pause_en),
  .cfg_bcast_en   (cfg_bcast_en),
  .cfg_bcast_chan (cfg_bcast_chan),
  .in_valid       (in_valid),
  .in_eof         (in_eof),
  .in_data        (in_data),
  .in_ucast       (in_ucast),
  .in_bcast       (in_bcast),
  .in_ctrl        (in_ctrl),
  .in_pause       (in_pause),
  .out_valid      (out_valid),
  .out_data       (out_data),
  .dec_valid      (dec_valid),
  .dec_accept     (dec_accept),
  .dec_chan       (dec_chan),
  .dec_flag_ctrl  (dec_flag_ctrl),
  .dec_flag_frag  (dec_flag_frag),
  .dec_flag_under (dec_flag_under),
  .pause_req      (pause_req)
);

// File: tb/test_eth_rx_filter.sv
module test_eth_rx_filter;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cfg_pass_fcs = 0, cfg_keep_ctrl = 0, cfg_keep_short = 0, cfg_pause_en = 0;
  logic       cfg_bcast_en = 0, cfg_mcast_en = 0, cfg_prom_en = 0;
  logic [2:0] cfg_bcast_chan = 0, cfg_mcast_chan = 0, cfg_prom_chan = 0;
  logic       in_valid = 0, in_sof = 0, in_eof = 0;
  logic [7:0] in_data = 0;
  logic       in_crc_err = 0, in_align_err = 0, in_code_err = 0;
  logic       in_ucast = 0, in_mcast = 0, in_bcast = 0, in_ctrl = 0, in_pause = 0;
  logic [2:0] in_ucast_chan = 3'd5;

  logic        out_valid, out_last, dec_valid, dec_accept;
  logic [7:0]  out_data;
  logic [2:0]  dec_chan;
  logic [15:0] dec_len;
  logic        dec_flag_ctrl, dec_flag_frag, dec_flag_under, pause_req;

  eth_rx_filter i_eth_rx_filter (
    .clk(clk), .rst_n(rst_n),
    .cfg_pass_fcs(cfg_pass_fcs), .cfg_keep_ctrl(cfg_keep_ctrl),
    .cfg_keep_short(cfg_keep_short), .cfg_pause_en(cfg_pause_en),
    .cfg_bcast_en(cfg_bcast_en), .cfg_bcast_chan(cfg_bcast_chan),
    .cfg_mcast_en(cfg_mcast_en), .cfg_mcast_chan(cfg_mcast_chan),
    .cfg_prom_en(cfg_prom_en), .cfg_prom_chan(cfg_prom_chan),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .in_crc_err(in_crc_err), .in_align_err(in_align_err), .in_code_err(in_code_err),
    .in_ucast(in_ucast), .in_ucast_chan(in_ucast_chan), .in_mcast(in_mcast),
    .in_bcast(in_bcast), .in_ctrl(in_ctrl), .in_pause(in_pause),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_chan(dec_chan),
    .dec_len(dec_len), .dec_flag_ctrl(dec_flag_ctrl), .dec_flag_frag(dec_flag_frag),
    .dec_flag_under(dec_flag_under), .pause_req(pause_req)
  );

  int n_chk = 0;
  int n_err = 0;
  int frame_no = 0;

  // expected verdict word: {accept, chan[2:0], len[15:0], ctrl, frag, under, pause}
  logic [23:0] exp_q[$];
  string       etag_q[$];
  logic [7:0]  dat_q[$];
  string       dtag_q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_frame(input int n, input int errsel, input bit uc, input bit mc,
                            input bit bc, input bit ctl, input bit pz,
                            input string tag, input bit gap);
    bit          err, shrt, hit, acc;
    logic [2:0]  ch;
    logic [15:0] len;
    err  = (errsel != 0);
    shrt = (n < 64);
    hit = 1; ch = 0;
    if (uc) ch = in_ucast_chan;
    else if (bc && cfg_bcast_en) ch = cfg_bcast_chan;
    else if (mc && cfg_mcast_en) ch = cfg_mcast_chan;
    else if (cfg_prom_en) ch = cfg_prom_chan;
    else hit = 0;
    if (ctl) acc = cfg_keep_ctrl;
    else if (shrt) acc = cfg_keep_short;
    else acc = hit;
    len = cfg_pass_fcs ? 16'(n) : ((n > 4) ? 16'(n - 4) : 16'd0);
    exp_q.push_back({acc, ch, len, acc & ctl, acc & !ctl & shrt & err,
                     acc & !ctl & shrt & !err, pz & cfg_pause_en});
    etag_q.push_back(tag);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'((i * 7) + (frame_no * 13));
      if (cfg_pass_fcs || (i < n - 4)) begin
        dat_q.push_back(b);
        dtag_q.push_back(cfg_pass_fcs ? "R2" : "R3");
      end
      in_valid = 1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = b;
      in_crc_err = (i == n - 1) && (errsel == 1);
      in_align_err = (i == n - 1) && (errsel == 2);
      in_code_err = (i == n - 1) && (errsel == 3);
      in_ucast = (i == n - 1) && uc;
      in_mcast = (i == n - 1) && mc;
      in_bcast = (i == n - 1) && bc;
      in_ctrl = (i == n - 1) && ctl;
      in_pause = (i == n - 1) && pz;
      @(posedge clk); #1;
    end
    in_valid = 0; in_sof = 0; in_eof = 0;
    in_crc_err = 0; in_align_err = 0; in_code_err = 0;
    in_ucast = 0; in_mcast = 0; in_bcast = 0; in_ctrl = 0; in_pause = 0;
    frame_no++;
    if (gap) begin @(posedge clk); #1; end
  endtask

  // monitor
  bit pend_eof = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (dat_q.size() == 0) check(0, "R3 unexpected byte", {24'd0, out_data}, 32'd0);
        else begin
          logic [7:0] e;
          string t;
          e = dat_q.pop_front(); t = dtag_q.pop_front();
          check(out_data == e, t, {24'd0, out_data}, {24'd0, e});
        end
      end
      if (pend_eof || dec_valid)
        check(dec_valid == pend_eof, "R4 verdict timing", {31'd0, dec_valid}, {31'd0, pend_eof});
      if (dec_valid) begin
        logic [23:0] act;
        act = {dec_accept, dec_chan, dec_len, dec_flag_ctrl, dec_flag_frag,
               dec_flag_under, pause_req};
        if (exp_q.size() == 0) check(0, "R4 extra verdict", {8'd0, act}, 32'd0);
        else begin
          logic [23:0] e;
          string t;
          e = exp_q.pop_front(); t = etag_q.pop_front();
          check(act == e, t, {8'd0, act}, {8'd0, e});
        end
      end
      pend_eof = in_valid && in_eof;
    end
  end

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid && !dec_valid && !pause_req, "R1 reset outputs",
          {29'd0, out_valid, dec_valid, pause_req}, 32'd0);
    rst_n = 1;
    @(posedge clk); #1;
    check(!out_valid && !dec_valid, "R1 idle after reset", {30'd0, out_valid, dec_valid}, 32'd0);

    // default configuration: CRC stripped, only unicast hits
    send_frame(100, 0, 1, 0, 0, 0, 0, "R8 unicast hit, R3 strip len", 1);
    send_frame(80, 0, 0, 1, 0, 0, 0, "R10 multicast disabled", 1);
    send_frame(80, 0, 0, 0, 1, 0, 0, "R9 broadcast disabled", 1);
    send_frame(70, 0, 1, 0, 0, 1, 0, "R5 control dropped", 1);
    send_frame(40, 0, 1, 0, 0, 0, 0, "R7 short dropped", 1);
    send_frame(80, 0, 0, 0, 0, 0, 0, "R11 no match dropped", 1);
    send_frame(3, 0, 1, 0, 0, 0, 0, "R3 tiny frame zero len", 1);
    send_frame(5, 0, 1, 0, 0, 0, 0, "R3 five byte frame", 1);

    cfg_pass_fcs = 1;
    send_frame(70, 0, 1, 0, 0, 0, 0, "R2 pass len", 1);
    cfg_pass_fcs = 0;

    cfg_bcast_en = 1; cfg_bcast_chan = 3'd2;
    cfg_mcast_en = 1; cfg_mcast_chan = 3'd3;
    send_frame(90, 0, 0, 0, 1, 0, 0, "R9 broadcast accepted", 1);
    send_frame(90, 0, 0, 1, 0, 0, 0, "R10 multicast accepted", 1);
    send_frame(90, 0, 0, 1, 1, 0, 0, "R12 bcast over mcast", 1);
    send_frame(90, 0, 1, 0, 1, 0, 0, "R12 unicast over bcast", 1);
    cfg_bcast_en = 0;
    send_frame(90, 0, 0, 1, 1, 0, 0, "R12 mcast when bcast off", 1);
    cfg_mcast_en = 0;
    cfg_prom_en = 1; cfg_prom_chan = 3'd6;
    send_frame(90, 0, 0, 0, 0, 0, 0, "R11 promiscuous catch", 1);
    send_frame(90, 0, 0, 1, 0, 0, 0, "R11 mcast falls to promiscuous", 1);
    cfg_prom_en = 0;

    cfg_keep_short = 1;
    send_frame(40, 1, 1, 0, 0, 0, 0, "R7 fragment crc", 1);
    send_frame(40, 2, 1, 0, 0, 0, 0, "R7 fragment align", 1);
    send_frame(40, 3, 0, 0, 0, 0, 0, "R7 fragment code", 1);
    send_frame(63, 0, 0, 0, 0, 0, 0, "R7 undersize 63", 1);
    send_frame(64, 0, 1, 0, 0, 0, 0, "R7 64 not short", 1);
    send_frame(64, 0, 0, 0, 0, 0, 0, "R7 64 unmatched dropped", 1);
    send_frame(70, 1, 1, 0, 0, 0, 0, "R13 long error no flag", 1);
    cfg_keep_short = 0;

    cfg_keep_ctrl = 1;
    send_frame(64, 0, 0, 1, 0, 1, 0, "R5 control kept flag", 1);
    send_frame(40, 1, 0, 0, 0, 1, 0, "R5 control beats short rule", 1);
    cfg_keep_ctrl = 0; cfg_pause_en = 1;
    send_frame(64, 0, 0, 1, 0, 1, 1, "R6 pause on dropped control", 1);
    cfg_keep_ctrl = 1;
    send_frame(64, 0, 0, 1, 0, 1, 1, "R6 pause on kept control", 1);
    cfg_pause_en = 0;
    send_frame(64, 0, 0, 1, 0, 1, 1, "R6 pause disabled", 1);
    cfg_keep_ctrl = 0;

    // back to back frames in both CRC modes
    send_frame(66, 0, 1, 0, 0, 0, 0, "R4 back to back a", 0);
    send_frame(2, 0, 1, 0, 0, 0, 0, "R4 back to back b", 0);
    send_frame(70, 0, 1, 0, 0, 0, 0, "R4 back to back c", 1);
    cfg_pass_fcs = 1;
    send_frame(65, 0, 1, 0, 0, 0, 0, "R2 back to back a", 0);
    send_frame(1, 0, 1, 0, 0, 0, 0, "R2 back to back b", 0);
    send_frame(68, 0, 1, 0, 0, 0, 0, "R2 back to back c", 1);
    cfg_pass_fcs = 0;

    repeat (4) @(posedge clk);
    #1;
    check(exp_q.size() == 0 && dat_q.size() == 0, "R4 all results delivered",
          exp_q.size(), 32'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule